// File: doc/BRIEF.md
# I2S to Latched-DAC Stopped-Clock Formatter

This block sits between an I2S stereo receiver and a multibit converter that loads a serial shift register and converts on a falling latch-enable edge. It oversamples the incoming I2S bit clock, word select and data on a fast master clock. It collects the upper bits of each left and right word and then sends the pair out again on a bit clock it generates itself. The left word goes on one data line and the right word on another, and both share the generated bit clock and one latch enable.

The output timing is chosen so that conversion happens while the digital lines are quiet. After the last bit of a pair has been shifted out, the generated bit clock stays low and the data lines hold their values. The latch enable is then pulled low after a fixed number of silent bit periods. The latch enable goes high again partway through the next transfer, at a bit-clock falling edge, so that the quiet window contains only the one conversion edge. If a channel word is cut short by an early word-select change, that frame is dropped and produces neither a transfer nor a conversion edge.

Top module: `i2s_ts_fmt`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, dac_le is 1 and dac_bck, dac_dl and dac_dr are 0.
- R2: I2S input is sampled on rising edges of i2s_bck_in. The first bit after a word-select change belongs to the previous word and is skipped. The next DAC_W bits form the word, MSB first. Word select 0 means left and 1 means right, and any bits after the DAC_W-th bit in a slot are ignored. A pair is produced when a complete left word is followed by a complete right word.
- R3: Each pair is sent as exactly DAC_W rising edges of dac_bck, MSB first, with left data on dac_dl and right data on dac_dr. Data changes only while dac_bck is low.
- R4: In the output, dac_bck is high for HALF_DIV master cycles per bit, and consecutive rising edges within a transfer are 2*HALF_DIV master cycles apart.
- R5: After the last bit of a transfer, dac_bck falls and stays low, and dac_dl and dac_dr stay constant until dac_le falls.
- R6: dac_le falls exactly QUIET_BITS*2*HALF_DIV master cycles after the last dac_bck falling edge of the transfer. There is exactly one such falling edge per transferred pair.
- R7: dac_le rises only on the dac_bck falling edge that begins bit LE_RISE_BIT of a transfer, where bit 0 is the MSB. This happens after LE_RISE_BIT rising edges of that transfer have occurred.
- R8: If word select changes before DAC_W bits of either word of a frame have been captured, that frame produces no dac_bck edges and no dac_le falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| i2s_bck_in | input | 1 | Incoming I2S bit clock, asynchronous |
| i2s_ws_in | input | 1 | Incoming I2S word select, 0 = left |
| i2s_sd_in | input | 1 | Incoming I2S serial data |
| dac_bck | output | 1 | Generated, gated bit clock to the converter |
| dac_le | output | 1 | Latch enable; conversion on its falling edge |
| dac_dl | output | 1 | Left channel serial data |
| dac_dr | output | 1 | Right channel serial data |

## Verification
Two events can land in the same master cycle. The first is the latch-enable rise, which must coincide with a bit-clock falling edge. The second is the completion of an incoming right word, which starts a transfer while the capture side keeps running. The bench runs frames back to back, so the input side is always active while a transfer, its quiet window and its latch-enable edge are under way. On every cycle, it checks that the latch-enable rise is seen on the same sample as the bit-clock fall and after the expected number of bits. Truncated left and right slots are mixed into the stream, and the words delivered at each conversion edge must still match the expected queue in order.

// File: rtl/i2s_ts_pkg.sv
package i2s_ts_pkg;

    // Output serializer phases
    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,   // clock stopped, waiting for a captured pair
        SER_LOW   = 2'd1,   // low half of an output bit, data presented
        SER_HIGH  = 2'd2,   // high half of an output bit
        SER_QUIET = 2'd3    // clock stopped, counting down to conversion
    } ser_state_e;

endpackage

// File: rtl/i2s_ts_sync.sv
module i2s_ts_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stg_q[i] <= '0;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/i2s_ts_capture.sv
module i2s_ts_capture #(
    parameter int DAC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bck,
    input  logic             ws,
    input  logic             sd,
    output logic             pair_vld,
    output logic [DAC_W-1:0] pair_l,
    output logic [DAC_W-1:0] pair_r
);

    localparam int CNT_W = $clog2(DAC_W + 1);

    typedef struct packed {
        logic             bck_prev;
        logic             ws_last;
        logic             active;
        logic             left_ok;
        logic [CNT_W-1:0] cnt;
        logic [DAC_W-1:0] sh;
        logic [DAC_W-1:0] left;
        logic             vld;
        logic [DAC_W-1:0] out_l;
        logic [DAC_W-1:0] out_r;
    } cap_t;

    cap_t             cap_d, cap_q;
    logic [DAC_W-1:0] sh_next;

    always_comb begin
        sh_next       = {cap_q.sh[DAC_W-2:0], sd};
        cap_d         = cap_q;
        cap_d.vld     = 1'b0;
        cap_d.bck_prev = bck;
        if (bck && !cap_q.bck_prev) begin
            if (ws != cap_q.ws_last) begin
                // slot boundary: this bit is the tail of the previous word
                cap_d.ws_last = ws;
                cap_d.active  = 1'b1;
                cap_d.cnt     = '0;
                if (!ws) cap_d.left_ok = 1'b0;
            end else if (cap_q.active && cap_q.cnt != CNT_W'(DAC_W)) begin
                cap_d.sh  = sh_next;
                cap_d.cnt = cap_q.cnt + 1'b1;
                if (cap_q.cnt == CNT_W'(DAC_W - 1)) begin
                    if (!ws) begin
                        cap_d.left    = sh_next;
                        cap_d.left_ok = 1'b1;
                    end else if (cap_q.left_ok) begin
                        cap_d.vld     = 1'b1;
                        cap_d.out_l   = cap_q.left;
                        cap_d.out_r   = sh_next;
                        cap_d.left_ok = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign pair_vld = cap_q.vld;
    assign pair_l   = cap_q.out_l;
    assign pair_r   = cap_q.out_r;

endmodule

// File: rtl/i2s_ts_serial.sv
module i2s_ts_serial
    import i2s_ts_pkg::*;
#(
    parameter int DAC_W       = 20,
    parameter int HALF_DIV    = 2,
    parameter int QUIET_BITS  = 4,
    parameter int LE_RISE_BIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DAC_W-1:0] in_l,
    input  logic [DAC_W-1:0] in_r,
    output logic             bck,
    output logic             le,
    output logic             dl,
    output logic             dr
);

    localparam int PH_W   = $clog2(HALF_DIV + 1);
    localparam int BIT_W  = $clog2(DAC_W);
    localparam int QCYC   = QUIET_BITS * 2 * HALF_DIV;
    localparam int Q_W    = $clog2(QCYC + 1);

    typedef struct packed {
        ser_state_e       st;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitn;
        logic [Q_W-1:0]   qc;
        logic [DAC_W-1:0] sh_l;
        logic [DAC_W-1:0] sh_r;
        logic             bck;
        logic             le;
        logic             dl;
        logic             dr;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d = ser_q;
        case (ser_q.st)
            SER_IDLE: begin
                // a pair arriving in any other state is dropped
                if (start) begin
                    ser_d.sh_l = in_l;
                    ser_d.sh_r = in_r;
                    ser_d.dl   = in_l[DAC_W-1];
                    ser_d.dr   = in_r[DAC_W-1];
                    ser_d.bitn = '0;
                    ser_d.ph   = '0;
                    ser_d.st   = SER_LOW;
                end
            end
            SER_LOW: begin
                if (ser_q.ph == PH_W'(HALF_DIV - 1)) begin
                    ser_d.ph  = '0;
                    ser_d.bck = 1'b1;
                    ser_d.st  = SER_HIGH;
                end else begin
                    ser_d.ph = ser_q.ph + 1'b1;
                end
            end
            SER_HIGH: begin
                if (ser_q.ph == PH_W'(HALF_DIV - 1)) begin
                    ser_d.ph  = '0;
                    ser_d.bck = 1'b0;
                    if (ser_q.bitn == BIT_W'(DAC_W - 1)) begin
                        ser_d.qc = '0;
                        ser_d.st = SER_QUIET;
                    end else begin
                        ser_d.bitn = ser_q.bitn + 1'b1;
                        ser_d.sh_l = {ser_q.sh_l[DAC_W-2:0], 1'b0};
                        ser_d.sh_r = {ser_q.sh_r[DAC_W-2:0], 1'b0};
                        ser_d.dl   = ser_q.sh_l[DAC_W-2];
                        ser_d.dr   = ser_q.sh_r[DAC_W-2];
                        ser_d.st   = SER_LOW;
                        if (ser_q.bitn == BIT_W'(LE_RISE_BIT - 1)) ser_d.le = 1'b1;
                    end
                end else begin
                    ser_d.ph = ser_q.ph + 1'b1;
                end
            end
            SER_QUIET: begin
                if (ser_q.qc == Q_W'(QCYC - 1)) begin
                    ser_d.le = 1'b0;
                    ser_d.st = SER_IDLE;
                end else begin
                    ser_d.qc = ser_q.qc + 1'b1;
                end
            end
            default: ser_d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q    <= '0;
            ser_q.le <= 1'b1;
        end else begin
            ser_q <= ser_d;
        end
    end

    assign bck = ser_q.bck;
    assign le  = ser_q.le;
    assign dl  = ser_q.dl;
    assign dr  = ser_q.dr;

endmodule

// File: rtl/i2s_ts_fmt.sv
module i2s_ts_fmt #(
    parameter int DAC_W       = 20,
    parameter int HALF_DIV    = 2,
    parameter int QUIET_BITS  = 4,
    parameter int LE_RISE_BIT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic i2s_bck_in,
    input  logic i2s_ws_in,
    input  logic i2s_sd_in,
    output logic dac_bck,
    output logic dac_le,
    output logic dac_dl,
    output logic dac_dr
);

    logic [2:0]       sync_out;
    logic             pair_vld;
    logic [DAC_W-1:0] pair_l;
    logic [DAC_W-1:0] pair_r;

    i2s_ts_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({i2s_bck_in, i2s_ws_in, i2s_sd_in}),
        .dout (sync_out)
    );

    i2s_ts_capture #(.DAC_W(DAC_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .bck      (sync_out[2]),
        .ws       (sync_out[1]),
        .sd       (sync_out[0]),
        .pair_vld (pair_vld),
        .pair_l   (pair_l),
        .pair_r   (pair_r)
    );

    i2s_ts_serial #(
        .DAC_W       (DAC_W),
        .HALF_DIV    (HALF_DIV),
        .QUIET_BITS  (QUIET_BITS),
        .LE_RISE_BIT (LE_RISE_BIT)
    ) u_ser (
        .clk   (clk),
        .rst   (rst),
        .start (pair_vld),
        .in_l  (pair_l),
        .in_r  (pair_r),
        .bck   (dac_bck),
        .le    (dac_le),
        .dl    (dac_dl),
        .dr    (dac_dr)
    );

endmodule

// File: rtl/i2s_ts_fmt_chk.sv
module i2s_ts_fmt_chk #(
    parameter int HALF_DIV   = 2,
    parameter int QUIET_BITS = 4
) (
    input logic clk,
    input logic rst,
    input logic dac_bck,
    input logic dac_le,
    input logic dac_dl,
    input logic dac_dr
);

    localparam int QCYC = QUIET_BITS * 2 * HALF_DIV;

    logic        bck_prev_q;
    logic [15:0] quiet_q;
    logic [15:0] high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_prev_q <= 1'b0;
            quiet_q    <= '0;
            high_q     <= '0;
        end else begin
            bck_prev_q <= dac_bck;
            if (bck_prev_q && !dac_bck)   quiet_q <= '0;
            else if (quiet_q != 16'hFFFF) quiet_q <= quiet_q + 1'b1;
            if (dac_bck) high_q <= high_q + 1'b1;
            else         high_q <= '0;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_le && !dac_bck && !dac_dl && !dac_dr)); // R1

    AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        dac_bck |-> ($stable(dac_dl) && $stable(dac_dr))); // R3

    AST_HIGH_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_bck) |-> (high_q == 16'(HALF_DIV))); // R4

    AST_QUIET_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_le) |-> (!dac_bck && quiet_q == 16'(QCYC - 1))); // R6

    AST_LE_RISE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_le) |-> $fell(dac_bck)); // R7

endmodule

bind i2s_ts_fmt i2s_ts_fmt_chk #(
    .HALF_DIV   (HALF_DIV),
    .QUIET_BITS (QUIET_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .dac_bck (dac_bck),
    .dac_le  (dac_le),
    .dac_dl  (dac_dl),
    .dac_dr  (dac_dr)
);

// File: tb/i2s_ts_fmt_bench.sv
`timescale 1ns/1ps
module i2s_ts_fmt_bench;

    localparam int W    = 20;
    localparam int H    = 2;
    localparam int QB   = 4;
    localparam int LRB  = 2;
    localparam int QCYC = QB * 2 * H;
    localparam int IBH  = 4;   // I2S half bit period in master cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck_i = 1'b0, ws_i = 1'b1, sd_i = 1'b0;
    logic dac_bck, dac_le, dac_dl, dac_dr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2*W-1:0] exp_q [$];
    int pushed = 0;

    i2s_ts_fmt #(.DAC_W(W), .HALF_DIV(H), .QUIET_BITS(QB), .LE_RISE_BIT(LRB)) u_i2s_ts_fmt (
        .clk(clk), .rst(rst),
        .i2s_bck_in(bck_i), .i2s_ws_in(ws_i), .i2s_sd_in(sd_i),
        .dac_bck(dac_bck), .dac_le(dac_le), .dac_dl(dac_dl), .dac_dr(dac_dr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // ---------------- cycle-by-cycle output model ----------------
    logic p_bck, p_le, p_dl, p_dr;
    int bits, qcnt, hcnt, since_rise, falls, rises_total;
    bit lsb_done;
    logic [W-1:0] acc_l, acc_r;
    logic [2*W-1:0] e;

    always @(negedge clk) begin
        if (rst) begin
            p_bck = dac_bck; p_le = dac_le; p_dl = dac_dl; p_dr = dac_dr;
            bits = 0; qcnt = 0; hcnt = 0; since_rise = 0; lsb_done = 0;
        end else begin
            since_rise++;
            if (dac_bck) hcnt++;
            if (dac_bck && !p_bck) begin
                if (bits > 0) chk(since_rise == 2*H, "R4", "rise spacing", since_rise, 2*H);
                since_rise = 0;
                chk(bits < W && !lsb_done, "R3", "extra clock in transfer", bits, W);
                acc_l = {acc_l[W-2:0], dac_dl};
                acc_r = {acc_r[W-2:0], dac_dr};
                bits++;
                rises_total++;
            end
            if (dac_bck)
                chk(dac_dl == p_dl && dac_dr == p_dr, "R3", "data moved while clock high",
                    {dac_dl, dac_dr}, {p_dl, p_dr});
            if (!dac_bck && p_bck) begin
                chk(hcnt == H, "R4", "high phase length", hcnt, H);
                hcnt = 0;
                if (bits == W) begin lsb_done = 1; qcnt = 0; end
            end else if (lsb_done) begin
                qcnt++;
                chk(!dac_bck && dac_dl == p_dl && dac_dr == p_dr, "R5", "lines not quiet",
                    {dac_bck, dac_dl, dac_dr}, {1'b0, p_dl, p_dr});
            end
            if (dac_le && !p_le)
                chk(!dac_bck && p_bck && bits == LRB, "R7", "latch rise placement", bits, LRB);
            if (!dac_le && p_le) begin
                falls++;
                chk(lsb_done && qcnt == QCYC, "R6", "quiet cycles before conversion", qcnt, QCYC);
                if (exp_q.size() == 0) begin
                    chk(0, "R8", "conversion with no expected pair", {acc_l, acc_r}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({acc_l, acc_r} == e, "R2", "converted pair", {acc_l, acc_r}, e);
                end
                bits = 0; lsb_done = 0;
            end
            p_bck = dac_bck; p_le = dac_le; p_dl = dac_dl; p_dr = dac_dr;
        end
    end

    // ---------------- I2S stimulus ----------------
    task automatic send_slot(input bit ch, input logic [23:0] w, input int len);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            bck_i = 1'b0;
            ws_i  = ch;
            sd_i  = (k >= 1 && k <= 24) ? w[24-k] : 1'b0;
            repeat (IBH - 1) @(negedge clk);
            @(negedge clk);
            bck_i = 1'b1;
            repeat (IBH - 1) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                              input int len_l, input int len_r);
        if (len_l == 32 && len_r == 32) begin
            exp_q.push_back({l[23:4], r[23:4]});
            pushed++;
        end
        send_slot(1'b0, l, len_l);
        send_slot(1'b1, r, len_r);
    endtask

    initial begin
        falls = 0; rises_total = 0; acc_l = '0; acc_r = '0;
        repeat (4) @(negedge clk);
        chk(dac_le == 1'b1, "R1", "reset latch enable", dac_le, 1);
        chk(dac_bck == 1'b0 && dac_dl == 1'b0 && dac_dr == 1'b0, "R1", "reset lines",
            {dac_bck, dac_dl, dac_dr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_le == 1'b1 && dac_bck == 1'b0, "R1", "first cycle after reset",
            {dac_le, dac_bck}, 2'b10);
        send_slot(1'b1, 24'h0, 32);  // lead-in right slot, never paired
        send_frame(24'hFFFFFF, 24'h000000, 32, 32);
        send_frame(24'hAAAAAA, 24'h555555, 32, 32);
        send_frame(24'h800000, 24'h7FFFFF, 32, 32);
        send_frame(24'h00000F, 24'h123456, 32, 32);  // R2: bits below the top 20 ignored
        send_frame(24'h13579B, 24'hFEDCBA, 12, 32);  // R8: short left word
        send_frame(24'h2468AC, 24'hC0FFEE, 32, 32);
        send_frame(24'h0F0F0F, 24'hBADBAD, 32, 12);  // R8: short right word
        for (int i = 0; i < 4; i++)
            send_frame(24'($urandom), 24'($urandom), 32, 32);
        send_slot(1'b0, 24'h0, 32);
        repeat (400) @(negedge clk);
        chk(falls == pushed, "R8", "conversion count", falls, pushed);
        chk(exp_q.size() == 0, "R6", "pairs left unconverted", exp_q.size(), 0);
        chk(rises_total == W * pushed, "R8", "total output clock edges", rises_total, W * pushed);
        chk(dac_bck == 1'b0 && dac_le == 1'b0, "R5", "idle lines after run",
            {dac_bck, dac_le}, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #500000;
        if (!done) begin
            chk(0, "R3", "watchdog expired", 0, 1);
            finish_run();
        end
    end

endmodule